// File: doc/BRIEF.md
# Sticky Interrupt Status Register

This block gathers event indications from a node's receive path and network controller into one status word of sticky bits. Each event source drives a single-cycle pulse or a level. The matching bit is set on the next clock edge and stays set until software clears it. Software reads the word and clears bits over a small register bus. A bus write clears every status bit whose data bit is zero and leaves every bit whose data bit is one as it is. So a read-modify-write of the value just read never drops an event that arrived in between.

A companion enable register selects which status bits take part in a single interrupt line. The line is the OR of the enabled status bits. The pending-initialisation bit follows an external "identifier queue not empty" level. It cannot be cleared while that queue still holds entries.

The reset-request bit only records the request; acting on it is left to software. Parameters set the data width, the address width, the two register addresses, and whether the interrupt line is combinational or registered.

Top module: `irq_status_reg`

## Requirements
- R1: While `rst_n` is low at a clock edge, every status bit and every enable bit becomes zero, and `irq_o` is low afterwards.
- R2: An event input that is high at a clock edge sets its status bit, and the bit stays set after the input falls. The bit positions are: sync loss 11, RX FIFO full 10, RX FIFO almost full 9, bad data 8, pending initialisation 7, rogue packet dropped 6, reset request 3.
- R3: A write to the status address (0) clears each implemented bit whose write-data bit is 0, and leaves each bit whose write-data bit is 1 unchanged.
- R4: When an event and a clearing write hit the same bit in the same cycle, the bit is set after that edge.
- R5: Bits 15:12, 5, 4 and 2:0 of both the status and enable registers always read 0, and writes to them have no effect.
- R6: While `init_nonempty_i` is high, status bit 7 stays set even through a clearing write. Once the input is low, a clearing write clears the bit.
- R7: The enable register is at address 1 and reads back the implemented bits written to it. `irq_o` is high exactly when some status bit and its enable bit are both 1, visible after the same edge that changes either of them (default combinational variant).
- R8: Setting the reset-request bit changes no other status bit and no enable bit. No internal state is reset by it.
- R9: Writes to any address other than 0 and 1 change neither register. Reads of such an address return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sync_loss_i | input | 1 | Receiver lost synchronisation |
| rx_full_i | input | 1 | RX FIFO reached full |
| rx_afull_i | input | 1 | RX FIFO reached almost-full |
| bad_data_i | input | 1 | Invalid received data seen |
| init_nonempty_i | input | 1 | Initialisation-identifier queue not empty (level) |
| rogue_drop_i | input | 1 | Rogue packet detected and removed |
| reset_req_i | input | 1 | Remote node asked for a board reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | DATA_W | Register write data |
| rd_addr | input | ADDR_W | Register read address |
| rd_data | output | DATA_W | Read data (combinational from `rd_addr`) |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The assertions assume that the event inputs and the write controls are synchronous to `clk` and settle before each rising edge. They treat `init_nonempty_i` as a level that may stay high for many cycles. The bench meets this by changing every input on the falling edge only, and by raising events both alone and in the same cycle as clearing writes. Reset is applied only as a synchronous level, so the checker's view of "the cycle before" is always a cycle in which `rst_n` was sampled.

// File: rtl/irq_status_pkg.sv
package irq_status_pkg;

   localparam int unsigned MIN_DATA_W = 12;
   localparam int unsigned MAX_DATA_W = 64;
   localparam int unsigned NUM_SRC    = 7;

   // Source index order: 6 = sync loss ... 0 = reset request
   localparam int unsigned POS_SYNC   = 11;
   localparam int unsigned POS_FULL   = 10;
   localparam int unsigned POS_AFULL  = 9;
   localparam int unsigned POS_BAD    = 8;
   localparam int unsigned POS_INIT   = 7;
   localparam int unsigned POS_ROGUE  = 6;
   localparam int unsigned POS_RSTREQ = 3;

   typedef struct packed {
      logic sync_loss;
      logic rx_full;
      logic rx_afull;
      logic bad_data;
      logic init_pend;
      logic rogue_drop;
      logic reset_req;
   } irq_src_t;

   function automatic int unsigned src_pos(input int unsigned idx);
      case (idx)
         6:       return POS_SYNC;
         5:       return POS_FULL;
         4:       return POS_AFULL;
         3:       return POS_BAD;
         2:       return POS_INIT;
         1:       return POS_ROGUE;
         default: return POS_RSTREQ;
      endcase
   endfunction

   function automatic logic [MAX_DATA_W-1:0] impl_mask();
      logic [MAX_DATA_W-1:0] m;
      m = '0;
      for (int unsigned i = 0; i < NUM_SRC; i++) m[src_pos(i)] = 1'b1;
      return m;
   endfunction

endpackage

// File: rtl/irq_sticky_bit.sv
module irq_sticky_bit (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);
   always_ff @(posedge clk) begin
      if (!rst_n)
         q_o <= 1'b0;
      else if (set_i)
         q_o <= 1'b1;
      else if (clr_i)
         q_o <= 1'b0;
   end
endmodule

// File: rtl/irq_enable_reg.sv
module irq_enable_reg #(
   parameter int unsigned           DATA_W = 16,
   parameter logic [DATA_W-1:0]     IMPL   = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_i,
   input  logic [DATA_W-1:0] d_i,
   output logic [DATA_W-1:0] q_o
);
   for (genvar g = 0; g < DATA_W; g++) begin : g_bit
      if (IMPL[g]) begin : g_live
         always_ff @(posedge clk) begin
            if (!rst_n)
               q_o[g] <= 1'b0;
            else if (we_i)
               q_o[g] <= d_i[g];
         end
      end else begin : g_tied
         assign q_o[g] = 1'b0;
      end
   end
endmodule

// File: rtl/irq_combine.sv
module irq_combine #(
   parameter int unsigned DATA_W     = 16,
   parameter bit          REGISTERED = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] status_i,
   input  logic [DATA_W-1:0] enable_i,
   output logic              irq_o
);
   logic any_hit;
   assign any_hit = |(status_i & enable_i);

   if (REGISTERED) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) irq_o <= 1'b0;
         else        irq_o <= any_hit;
      end
   end else begin : g_comb
      assign irq_o = any_hit;
   end
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg
   import irq_status_pkg::*;
#(
   parameter int unsigned DATA_W         = 16,
   parameter int unsigned ADDR_W         = 4,
   parameter int unsigned STATUS_ADDR    = 0,
   parameter int unsigned ENABLE_ADDR    = 1,
   parameter bit          IRQ_REGISTERED = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sync_loss_i,
   input  logic              rx_full_i,
   input  logic              rx_afull_i,
   input  logic              bad_data_i,
   input  logic              init_nonempty_i,
   input  logic              rogue_drop_i,
   input  logic              reset_req_i,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              irq_o
);
   localparam logic [MAX_DATA_W-1:0] IMPL_ALL = impl_mask();
   localparam logic [DATA_W-1:0]     IMPL     = IMPL_ALL[DATA_W-1:0];
   localparam logic [ADDR_W-1:0]     A_STAT   = ADDR_W'(STATUS_ADDR);
   localparam logic [ADDR_W-1:0]     A_ENAB   = ADDR_W'(ENABLE_ADDR);

   if (DATA_W < MIN_DATA_W || DATA_W > MAX_DATA_W) begin : g_bad_width
      $error("irq_status_reg: DATA_W out of range");
   end
   if (STATUS_ADDR == ENABLE_ADDR) begin : g_bad_addr
      $error("irq_status_reg: register addresses collide");
   end
   if (ADDR_W > 31 || STATUS_ADDR >= (1 << ADDR_W) || ENABLE_ADDR >= (1 << ADDR_W)) begin : g_bad_aw
      $error("irq_status_reg: address does not fit ADDR_W");
   end

   irq_src_t          src;
   logic [DATA_W-1:0] ev_vec;
   logic [DATA_W-1:0] clr_vec;
   logic [DATA_W-1:0] status_q;
   logic [DATA_W-1:0] enable_q;
   logic              wr_stat;
   logic              wr_enab;

   assign src = '{sync_loss:  sync_loss_i,
                  rx_full:    rx_full_i,
                  rx_afull:   rx_afull_i,
                  bad_data:   bad_data_i,
                  init_pend:  init_nonempty_i,
                  rogue_drop: rogue_drop_i,
                  reset_req:  reset_req_i};

   always_comb begin
      ev_vec = '0;
      for (int unsigned i = 0; i < NUM_SRC; i++)
         ev_vec[src_pos(i)] = src[i];
   end

   assign wr_stat = wr_en && (wr_addr == A_STAT);
   assign wr_enab = wr_en && (wr_addr == A_ENAB);
   assign clr_vec = wr_stat ? ~wr_data : '0;

   for (genvar g = 0; g < DATA_W; g++) begin : g_stat
      if (IMPL[g]) begin : g_live
         irq_sticky_bit u_bit (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (ev_vec[g]),
            .clr_i (clr_vec[g]),
            .q_o   (status_q[g])
         );
      end else begin : g_tied
         assign status_q[g] = 1'b0;
      end
   end

   irq_enable_reg #(.DATA_W(DATA_W), .IMPL(IMPL)) u_enable (
      .clk   (clk),
      .rst_n (rst_n),
      .we_i  (wr_enab),
      .d_i   (wr_data),
      .q_o   (enable_q)
   );

   irq_combine #(.DATA_W(DATA_W), .REGISTERED(IRQ_REGISTERED)) u_combine (
      .clk      (clk),
      .rst_n    (rst_n),
      .status_i (status_q),
      .enable_i (enable_q),
      .irq_o    (irq_o)
   );

   always_comb begin
      if (rd_addr == A_STAT)      rd_data = status_q;
      else if (rd_addr == A_ENAB) rd_data = enable_q;
      else                        rd_data = '0;
   end
endmodule

// File: rtl/irq_status_chk.sv
module irq_status_chk
   import irq_status_pkg::*;
#(
   parameter int unsigned DATA_W         = 16,
   parameter int unsigned ADDR_W         = 4,
   parameter int unsigned STATUS_ADDR    = 0,
   parameter int unsigned ENABLE_ADDR    = 1,
   parameter bit          IRQ_REGISTERED = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic [DATA_W-1:0] ev_vec,
   input logic              init_nonempty_i,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [DATA_W-1:0] wr_data,
   input logic [DATA_W-1:0] status_q,
   input logic [DATA_W-1:0] enable_q,
   input logic              irq_o
);
   localparam logic [MAX_DATA_W-1:0] IMPL_ALL = impl_mask();
   localparam logic [DATA_W-1:0]     IMPL     = IMPL_ALL[DATA_W-1:0];

   logic              wr_stat;
   logic [DATA_W-1:0] zero_bits;
   assign wr_stat   = wr_en && (wr_addr == ADDR_W'(STATUS_ADDR));
   assign zero_bits = wr_stat ? ~wr_data : '0;

   // R1: one cycle after reset is sampled, everything is clear
   assert_reset_clear_R1: assert property (@(posedge clk)
      !rst_n |=> (status_q == '0 && enable_q == '0));

   // R2 / R4: a sampled event always leaves its bit set
   assert_event_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> ((($past(ev_vec) & IMPL) & ~status_q) == '0));

   // R3: a set bit without a zero write and without an event holds
   assert_sticky_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (($past(status_q) & ~$past(zero_bits)) & ~status_q) == '0);

   // R3: a bit with no event never rises
   assert_no_spurious_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> ((status_q & ~$past(status_q) & ~$past(ev_vec)) == '0));

   // R5: unimplemented positions stay zero
   assert_reserved_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ((status_q | enable_q) & ~IMPL) == '0);

   // R6: pending-init bit is held while the queue level is high
   assert_init_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      init_nonempty_i |=> status_q[POS_INIT]);

   if (!IRQ_REGISTERED) begin : g_irq_comb
      // R7: interrupt line follows enabled status bits
      assert_irq_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
         irq_o == ((status_q & enable_q) != '0));
   end else begin : g_irq_reg
      assert_irq_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
         $past(rst_n) |-> irq_o == (($past(status_q) & $past(enable_q)) != '0));
   end
endmodule

bind irq_status_reg irq_status_chk #(
   .DATA_W         (DATA_W),
   .ADDR_W         (ADDR_W),
   .STATUS_ADDR    (STATUS_ADDR),
   .ENABLE_ADDR    (ENABLE_ADDR),
   .IRQ_REGISTERED (IRQ_REGISTERED)
) u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .ev_vec          (ev_vec),
   .init_nonempty_i (init_nonempty_i),
   .wr_en           (wr_en),
   .wr_addr         (wr_addr),
   .wr_data         (wr_data),
   .status_q        (status_q),
   .enable_q        (enable_q),
   .irq_o           (irq_o)
);

// File: tb/sim_irq_status_reg.sv
module sim_irq_status_reg;
   localparam time CLK_PERIOD = 10ns;
   localparam int  DW = 16;
   localparam int  AW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [6:0]    src = '0;   // 6 sync,5 full,4 afull,3 bad,2 init,1 rogue,0 rstreq
   logic          wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic [AW-1:0] rd_addr = '0;
   logic [DW-1:0] rd_data;
   logic          irq_o;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   irq_status_reg u0 (
      .clk(clk), .rst_n(rst_n),
      .sync_loss_i(src[6]), .rx_full_i(src[5]), .rx_afull_i(src[4]),
      .bad_data_i(src[3]), .init_nonempty_i(src[2]), .rogue_drop_i(src[1]),
      .reset_req_i(src[0]),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .irq_o(irq_o)
   );

   function automatic int pos_of(input int i);
      return (i >= 1) ? i + 5 : 3;
   endfunction

   function automatic logic [DW-1:0] expand(input logic [6:0] m);
      logic [DW-1:0] v = '0;
      for (int i = 0; i < 7; i++) if (m[i]) v[pos_of(i)] = 1'b1;
      return v;
   endfunction

   task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] v);
      rd_addr = a;
      #1;
      v = rd_data;
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic pulse(input logic [6:0] m);
      src = m;
      @(negedge clk);
      src = '0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=%h expected=%h", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [DW-1:0] v;
      src = 7'h7F;
      repeat (3) @(negedge clk);
      src = '0;
      rst_n = 1'b1;
      // R1: reset state
      rd(0, v); check("R1 status", v, '0);
      rd(1, v); check("R1 enable", v, '0);
      check("R1 irq", {15'd0, irq_o}, '0);

      // R2/R3 per bit: set, hold, write-one keeps, write-zero clears
      for (int i = 0; i < 7; i++) begin
         pulse(7'(1 << i));
         rd(0, v); check("R2 set", v, expand(7'(1 << i)));
         @(negedge clk);
         rd(0, v); check("R2 hold", v, expand(7'(1 << i)));
         wr(0, '1);
         rd(0, v); check("R3 write one", v, expand(7'(1 << i)));
         wr(0, ~expand(7'(1 << i)));
         rd(0, v); check("R3 write zero", v, '0);
      end

      // R7: status pattern sweep with all enables on
      wr(1, '1);
      rd(1, v); check("R7 enable readback", v, expand(7'h7F));
      for (int p = 0; p < 128; p++) begin
         pulse(7'(p));
         rd(0, v); check("R2 pattern", v, expand(7'(p)));
         check("R7 irq pattern", {15'd0, irq_o}, {15'd0, p != 0});
         // R3: partial clear keeps the one-bits
         wr(0, expand(7'(p)) & 16'h0F00);
         rd(0, v); check("R3 partial", v, expand(7'(p)) & 16'h0F00);
         wr(0, '0);
      end

      // R7: enable sweep with all status set
      pulse(7'h7F);
      for (int m = 0; m < 128; m++) begin
         wr(1, expand(7'(m)) | 16'hF037);
         rd(1, v); check("R5 enable reserved", v, expand(7'(m)));
         check("R7 irq mask", {15'd0, irq_o}, {15'd0, m != 0});
      end
      wr(1, '1);

      // R5: reserved positions in status
      wr(0, 16'h0FC8);
      rd(0, v); check("R5 status reserved", v, 16'h0FC8);

      // R9: other addresses ignored and read zero
      for (int a = 2; a < 16; a++) begin
         wr(4'(a), '0);
         rd(4'(a), v); check("R9 read other", v, '0);
      end
      rd(0, v); check("R9 status kept", v, 16'h0FC8);
      rd(1, v); check("R9 enable kept", v, expand(7'h7F));

      // R4: event and clear in the same cycle
      wr(0, '0);
      src = 7'h40; wr_en = 1'b1; wr_addr = 0; wr_data = '0;
      @(negedge clk);
      src = '0; wr_en = 1'b0;
      rd(0, v); check("R4 event wins", v, 16'h0800);

      // R8: reset request does not disturb other state
      pulse(7'h01);
      rd(0, v); check("R8 status", v, 16'h0808);
      rd(1, v); check("R8 enable", v, expand(7'h7F));
      wr(0, '0);

      // R6: pending-init held while queue non-empty
      src = 7'h04;
      @(negedge clk);
      rd(0, v); check("R6 set", v, 16'h0080);
      wr(0, '0);
      rd(0, v); check("R6 held", v, 16'h0080);
      src = '0;
      @(negedge clk);
      rd(0, v); check("R6 sticky", v, 16'h0080);
      wr(0, '0);
      rd(0, v); check("R6 cleared", v, '0);
      check("R7 irq idle", {15'd0, irq_o}, '0);

      // R1: reset mid-run clears everything
      pulse(7'h7F);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      rd(0, v); check("R1 status again", v, '0);
      rd(1, v); check("R1 enable again", v, '0);
      check("R1 irq again", {15'd0, irq_o}, '0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule